// File: doc/BRIEF.md
# PCI Address Window Translator

This block converts addresses between a 32-bit system bus and a 32-bit PCI bus through programmable windows. On the outbound side, a system-bus address is compared against two windows, one that produces PCI memory cycles and one that produces PCI I/O cycles. On a hit, the offset inside the window is kept and the upper bits are replaced by a programmed PCI target base. Only a programmable slice at the bottom of each window is mapped. Accesses past the slice do not hit.

On the inbound side, a PCI memory address is decoded against a base address register. That register has one of six sizes and must be enabled. A hit is relocated into local memory at a programmed local base.

Configuration is held in registers that a simple write port loads. Both translations are combinational from those registers. Bus sequencing, data movement and configuration-cycle decoding live elsewhere.

Top module: `ptr_addr_xlate`

## Requirements
- R1: A window size code n in 0..5 (bits [2:0] of a control write) selects a window of 2^(18+2n) bytes: 256 KB, 1 MB, 4 MB, 16 MB, 64 MB or 256 MB. A control write whose code is 6 or 7 is ignored entirely, so the previous size, enable and slice remain in force.
- R2: The memory window hits when all of the following hold: its enable (control bit 3) is set, the address matches its system base above the window size, and the offset is below the slice. On a hit, ob_pci_addr is the PCI target base above the slice size joined with the address below it, and ob_is_io is 0.
- R3: The I/O window hits under the same rules with its own registers, and a hit on it alone sets ob_is_io to 1.
- R4: The mapped slice is 2^s bytes, where s is taken from control bits [8:4] and clamped to the range from 12 up to the window's log2 size. An offset of 2^s or more misses.
- R5: When both outbound windows hit, the memory window's translation is output and ob_is_io is 0.
- R6: When no outbound window hits, ob_hit is 0, ob_is_io is 0 and ob_pci_addr is 0.
- R7: When the inbound control enable (bit 3) is set and pci_addr matches the BAR above the selected size, ib_hit is 1. In that case ib_local_addr is the local base above the size joined with pci_addr below it.
- R8: When the inbound window is disabled or the address misses, ib_hit is 0 and ib_local_addr is 0.
- R9: Bits of a system base or BAR below the window size, and bits of a target or local base below the mapped size, have no effect on translation.
- R10: A register write changes the outputs only after the clock edge on which cfg_we is sampled high. Between writes, the outputs follow the address inputs combinationally.
- R11: After reset, every register is zero, both outbound windows and the inbound window are disabled, and nothing hits.

Register select (cfg_sel): 0 memory system base, 1 memory target base, 2 memory control, 3 I/O system base, 4 I/O target base, 5 I/O control, 6 inbound BAR, 7 inbound local base, 8 inbound control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| ahb_addr | input | 32 | System-bus address to translate outbound |
| ob_hit | output | 1 | Outbound address hits a window |
| ob_is_io | output | 1 | Outbound hit generates a PCI I/O cycle |
| ob_pci_addr | output | 32 | Translated PCI address, zero on miss |
| pci_addr | input | 32 | PCI memory address to decode inbound |
| ib_hit | output | 1 | Inbound address hits the BAR |
| ib_local_addr | output | 32 | Translated local address, zero on miss |

## Verification
The bench tests addresses at the last byte of each slice and of each of the six window sizes, and at the first byte past them. A design with an off-by-one mask, or one that ignores the slice, would accept the address past the end. It programs overlapping windows, where a wrong priority would flag a memory access as I/O. It writes bases with garbage low bits, which a design that fails to mask them would copy into translated addresses. It also writes reserved size codes, which a careless design would decode as a real size or use to clear the enable. One write is checked on both sides of its clock edge, to catch configuration that passes straight through to the outputs.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  localparam int unsigned MIN_WIN_LG2 = 18;
  localparam int unsigned NUM_SIZES   = 6;
  localparam int unsigned MIN_SLICE   = 12;
  localparam int unsigned OB_STRIDE   = 3;

  localparam logic [3:0] SEL_IB_BAR  = 4'd6;
  localparam logic [3:0] SEL_IB_LOC  = 4'd7;
  localparam logic [3:0] SEL_IB_CTRL = 4'd8;

  typedef struct packed {
    logic [4:0] slice;
    logic       en;
    logic [2:0] code;
  } win_ctrl_t;

  function automatic logic [5:0] win_lg2(input logic [2:0] code);
    return 6'(MIN_WIN_LG2) + {2'b00, code, 1'b0};
  endfunction

endpackage

// File: rtl/ptr_cfg_regs.sv
module ptr_cfg_regs
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_LG2 = MIN_WIN_LG2,
  parameter int unsigned TGT_LG2  = MIN_SLICE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [3:0]                   cfg_sel,
  input  logic [ADDR_W-1:0]            cfg_wdata,
  output logic [1:0][ADDR_W-1:0]       ob_base_o,
  output logic [1:0][ADDR_W-1:0]       ob_tgt_o,
  output win_ctrl_t [1:0]              ob_ctrl_o,
  output logic [ADDR_W-1:0]            ib_bar_o,
  output logic [ADDR_W-1:0]            ib_loc_o,
  output win_ctrl_t                    ib_ctrl_o
);

  localparam logic [ADDR_W-1:0] BASE_LO = (ADDR_W'(1) << GRAN_LG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TGT_LO  = (ADDR_W'(1) << TGT_LG2) - ADDR_W'(1);

  logic [1:0][ADDR_W-1:0] ob_base_q, ob_base_d;
  logic [1:0][ADDR_W-1:0] ob_tgt_q,  ob_tgt_d;
  win_ctrl_t [1:0]        ob_ctrl_q, ob_ctrl_d;
  logic [ADDR_W-1:0]      ib_bar_q, ib_bar_d;
  logic [ADDR_W-1:0]      ib_loc_q, ib_loc_d;
  win_ctrl_t              ib_ctrl_q, ib_ctrl_d;

  win_ctrl_t wr_ctrl;
  logic      code_ok;

  assign wr_ctrl = '{slice: cfg_wdata[8:4], en: cfg_wdata[3], code: cfg_wdata[2:0]};
  assign code_ok = (cfg_wdata[2:0] < 3'(NUM_SIZES));

  always_comb begin
    ob_base_d = ob_base_q;
    ob_tgt_d  = ob_tgt_q;
    ob_ctrl_d = ob_ctrl_q;
    ib_bar_d  = ib_bar_q;
    ib_loc_d  = ib_loc_q;
    ib_ctrl_d = ib_ctrl_q;
    for (int w = 0; w < 2; w++) begin
      if (cfg_sel == 4'(OB_STRIDE * w))
        ob_base_d[w] = cfg_wdata & ~BASE_LO;
      if (cfg_sel == 4'(OB_STRIDE * w + 1))
        ob_tgt_d[w] = cfg_wdata & ~TGT_LO;
      if (cfg_sel == 4'(OB_STRIDE * w + 2) && code_ok)
        ob_ctrl_d[w] = wr_ctrl;
    end
    if (cfg_sel == SEL_IB_BAR)
      ib_bar_d = cfg_wdata & ~BASE_LO;
    if (cfg_sel == SEL_IB_LOC)
      ib_loc_d = cfg_wdata & ~BASE_LO;
    if (cfg_sel == SEL_IB_CTRL && code_ok)
      ib_ctrl_d = '{slice: 5'd0, en: wr_ctrl.en, code: wr_ctrl.code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_base_q <= '0;
      ob_tgt_q  <= '0;
      ob_ctrl_q <= '0;
      ib_bar_q  <= '0;
      ib_loc_q  <= '0;
      ib_ctrl_q <= '0;
    end else if (cfg_we) begin
      ob_base_q <= ob_base_d;
      ob_tgt_q  <= ob_tgt_d;
      ob_ctrl_q <= ob_ctrl_d;
      ib_bar_q  <= ib_bar_d;
      ib_loc_q  <= ib_loc_d;
      ib_ctrl_q <= ib_ctrl_d;
    end
  end

  assign ob_base_o = ob_base_q;
  assign ob_tgt_o  = ob_tgt_q;
  assign ob_ctrl_o = ob_ctrl_q;
  assign ib_bar_o  = ib_bar_q;
  assign ib_loc_o  = ib_loc_q;
  assign ib_ctrl_o = ib_ctrl_q;

endmodule

// File: rtl/ptr_ob_window.sv
module ptr_ob_window
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] tgt,
  input  win_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);

  logic [5:0]        wl;
  logic [5:0]        sl;
  logic [ADDR_W-1:0] win_lo;
  logic [ADDR_W-1:0] sl_lo;

  always_comb begin
    wl = win_lg2(ctrl.code);
    if ({1'b0, ctrl.slice} < 6'(MIN_SLICE))
      sl = 6'(MIN_SLICE);
    else if ({1'b0, ctrl.slice} > wl)
      sl = wl;
    else
      sl = {1'b0, ctrl.slice};
    win_lo = ~({ADDR_W{1'b1}} << wl);
    sl_lo  = ~({ADDR_W{1'b1}} << sl);
    hit    = ctrl.en
             && (((addr ^ base) & ~win_lo) == '0)
             && ((addr & win_lo & ~sl_lo) == '0);
    xaddr  = hit ? ((tgt & ~sl_lo) | (addr & sl_lo)) : '0;
  end

endmodule

// File: rtl/ptr_ib_window.sv
module ptr_ib_window
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bar,
  input  logic [ADDR_W-1:0] loc,
  input  logic              en,
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);

  logic [ADDR_W-1:0] win_lo;

  always_comb begin
    win_lo = ~({ADDR_W{1'b1}} << win_lg2(code));
    hit    = en && (((addr ^ bar) & ~win_lo) == '0);
    xaddr  = hit ? ((loc & ~win_lo) | (addr & win_lo)) : '0;
  end

endmodule

// File: rtl/ptr_addr_xlate.sv
module ptr_addr_xlate
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] ahb_addr,
  output logic              ob_hit,
  output logic              ob_is_io,
  output logic [ADDR_W-1:0] ob_pci_addr,
  input  logic [ADDR_W-1:0] pci_addr,
  output logic              ib_hit,
  output logic [ADDR_W-1:0] ib_local_addr
);

  localparam int unsigned W_MEM = 0;
  localparam int unsigned W_IO  = 1;

  logic [1:0][ADDR_W-1:0] ob_base;
  logic [1:0][ADDR_W-1:0] ob_tgt;
  win_ctrl_t [1:0]        ob_ctrl;
  logic [ADDR_W-1:0]      ib_bar;
  logic [ADDR_W-1:0]      ib_loc;
  win_ctrl_t              ib_ctrl;
  logic [1:0]             w_hit;
  logic [1:0][ADDR_W-1:0] w_xaddr;

  ptr_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ob_base_o (ob_base),
    .ob_tgt_o  (ob_tgt),
    .ob_ctrl_o (ob_ctrl),
    .ib_bar_o  (ib_bar),
    .ib_loc_o  (ib_loc),
    .ib_ctrl_o (ib_ctrl)
  );

  for (genvar w = 0; w < 2; w++) begin : g_ob
    ptr_ob_window #(.ADDR_W(ADDR_W)) u_win (
      .base  (ob_base[w]),
      .tgt   (ob_tgt[w]),
      .ctrl  (ob_ctrl[w]),
      .addr  (ahb_addr),
      .hit   (w_hit[w]),
      .xaddr (w_xaddr[w])
    );
  end

  // memory window has priority over the I/O window
  always_comb begin
    ob_hit      = w_hit[W_MEM] | w_hit[W_IO];
    ob_is_io    = !w_hit[W_MEM] && w_hit[W_IO];
    ob_pci_addr = w_hit[W_MEM] ? w_xaddr[W_MEM] : w_xaddr[W_IO];
  end

  logic [4:0] ib_slice_unused;
  assign ib_slice_unused = ib_ctrl.slice;

  ptr_ib_window #(.ADDR_W(ADDR_W)) u_ib (
    .bar   (ib_bar),
    .loc   (ib_loc),
    .en    (ib_ctrl.en),
    .code  (ib_ctrl.code),
    .addr  (pci_addr),
    .hit   (ib_hit),
    .xaddr (ib_local_addr)
  );

endmodule

// File: rtl/ptr_addr_xlate_chk.sv
module ptr_addr_xlate_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] ahb_addr,
  input logic              ob_hit,
  input logic              ob_is_io,
  input logic [ADDR_W-1:0] ob_pci_addr,
  input logic [ADDR_W-1:0] pci_addr,
  input logic              ib_hit,
  input logic [ADDR_W-1:0] ib_local_addr
);

  AST_OB_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_hit |-> (ob_pci_addr == '0) && !ob_is_io); // R6

  AST_IO_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ob_is_io |-> ob_hit); // R3

  AST_OB_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> (ob_pci_addr[11:0] == ahb_addr[11:0])); // R2

  AST_IB_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_hit |-> (ib_local_addr == '0)); // R8

  AST_IB_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ib_hit |-> (ib_local_addr[17:0] == pci_addr[17:0])); // R7

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(ahb_addr) && $stable(pci_addr))
      |-> ($stable(ob_pci_addr) && $stable(ob_hit) && $stable(ib_local_addr))); // R10

endmodule

bind ptr_addr_xlate ptr_addr_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .ahb_addr      (ahb_addr),
  .ob_hit        (ob_hit),
  .ob_is_io      (ob_is_io),
  .ob_pci_addr   (ob_pci_addr),
  .pci_addr      (pci_addr),
  .ib_hit        (ib_hit),
  .ib_local_addr (ib_local_addr)
);

// File: tb/ptr_addr_xlate_tb.sv
module ptr_addr_xlate_tb;

  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] ahb_addr;
  logic        ob_hit;
  logic        ob_is_io;
  logic [31:0] ob_pci_addr;
  logic [31:0] pci_addr;
  logic        ib_hit;
  logic [31:0] ib_local_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of programmed state
  logic [31:0] m_base [2];
  logic [31:0] m_tgt  [2];
  logic [2:0]  m_code [2];
  logic        m_en   [2];
  logic [4:0]  m_sl   [2];
  logic [31:0] m_bar, m_loc;
  logic [2:0]  m_icode;
  logic        m_ien;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ahb_addr(ahb_addr), .ob_hit(ob_hit),
    .ob_is_io(ob_is_io), .ob_pci_addr(ob_pci_addr), .pci_addr(pci_addr),
    .ib_hit(ib_hit), .ib_local_addr(ib_local_addr)
  );

  function automatic int lg(input logic [2:0] c);
    return 18 + 2 * int'(c);
  endfunction

  function automatic void win_eval(input int w, input logic [31:0] a,
                                   output logic h, output logic [31:0] x);
    int wl, sl;
    logic [31:0] wlo, slo;
    wl = lg(m_code[w]);
    sl = int'(m_sl[w]);
    if (sl < 12) sl = 12;
    if (sl > wl) sl = wl;
    wlo = (32'h1 << wl) - 1;
    slo = (32'h1 << sl) - 1;
    h = m_en[w] && (((a ^ m_base[w]) & ~wlo) == 0) && (((a & wlo) >> sl) == 0);
    x = h ? ((m_tgt[w] & ~slo) | (a & slo)) : 32'h0;
  endfunction

  function automatic logic [33:0] exp_ob(input logic [31:0] a);
    logic hm, hi;
    logic [31:0] xm, xi;
    win_eval(0, a, hm, xm);
    win_eval(1, a, hi, xi);
    if (hm) return {1'b1, 1'b0, xm};
    if (hi) return {1'b1, 1'b1, xi};
    return 34'h0;
  endfunction

  function automatic logic [32:0] exp_ib(input logic [31:0] a);
    logic [31:0] wlo;
    wlo = (32'h1 << lg(m_icode)) - 1;
    if (m_ien && (((a ^ m_bar) & ~wlo) == 0))
      return {1'b1, (m_loc & ~wlo) | (a & wlo)};
    return 33'h0;
  endfunction

  function automatic void model_wr(input logic [3:0] s, input logic [31:0] d);
    case (s)
      4'd0: m_base[0] = d;
      4'd1: m_tgt[0]  = d;
      4'd3: m_base[1] = d;
      4'd4: m_tgt[1]  = d;
      4'd6: m_bar = d;
      4'd7: m_loc = d;
      4'd2, 4'd5: if (d[2:0] < 3'd6) begin
        m_code[s/3] = d[2:0]; m_en[s/3] = d[3]; m_sl[s/3] = d[8:4];
      end
      4'd8: if (d[2:0] < 3'd6) begin
        m_icode = d[2:0]; m_ien = d[3];
      end
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] ctl(input int code, input bit en, input int sl);
    return {23'h0, 5'(sl), en, 3'(code)};
  endfunction

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_wr(s, d);
  endtask

  // compare outbound outputs now (inputs already driven) against the model
  task automatic cmp_ob(input string req, input logic [33:0] e);
    checks++;
    if ({ob_hit, ob_is_io, ob_pci_addr} !== e) begin
      errors++;
      $display("FAIL %s ahb=%h got hit=%b io=%b addr=%h exp hit=%b io=%b addr=%h",
               req, ahb_addr, ob_hit, ob_is_io, ob_pci_addr, e[33], e[32], e[31:0]);
    end
  endtask

  task automatic chk_ob(input string req, input logic [31:0] a);
    @(negedge clk);
    ahb_addr = a;
    #1;
    cmp_ob(req, exp_ob(a));
  endtask

  task automatic chk_ib(input string req, input logic [31:0] a);
    logic [32:0] e;
    @(negedge clk);
    pci_addr = a;
    #1;
    e = exp_ib(a);
    checks++;
    if ({ib_hit, ib_local_addr} !== e) begin
      errors++;
      $display("FAIL %s pci=%h got hit=%b addr=%h exp hit=%b addr=%h",
               req, a, ib_hit, ib_local_addr, e[32], e[31:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < 2; w++) begin
      m_base[w] = 0; m_tgt[w] = 0; m_code[w] = 0; m_en[w] = 0; m_sl[w] = 0;
    end
    m_bar = 0; m_loc = 0; m_icode = 0; m_ien = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    ahb_addr = '0; pci_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state: nothing hits
    chk_ob("R11", 32'h0000_0000);
    chk_ib("R11", 32'h0000_0000);

    // memory window 256MB at 0x8000_0000 -> 0xF000_0000, 128MB slice
    wr(4'd0, 32'h8000_0000);
    wr(4'd1, 32'hF000_0000);
    // R10: write lands only at the clock edge
    @(negedge clk);
    ahb_addr = 32'h8123_4567;
    cfg_we = 1'b1; cfg_sel = 4'd2; cfg_wdata = ctl(5, 1, 27);
    #1;
    cmp_ob("R10", 34'h0);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    model_wr(4'd2, ctl(5, 1, 27));
    cmp_ob("R10", {2'b10, 32'hF123_4567});

    chk_ob("R2", 32'h8123_4567);
    chk_ob("R2", 32'h87FF_FFFF);
    chk_ob("R4", 32'h8800_0000);
    chk_ob("R6", 32'h7FFF_FFFF);

    // I/O window 256MB at 0xA000_0000 -> 0x2000_0000, 64KB slice
    wr(4'd3, 32'hA000_0000);
    wr(4'd4, 32'h2000_0000);
    wr(4'd5, ctl(5, 1, 16));
    chk_ob("R3", 32'hA000_1234);
    chk_ob("R3", 32'hA000_FFFF);
    chk_ob("R4", 32'hA001_0000);

    // R1: reserved size codes leave the window untouched
    wr(4'd2, ctl(7, 0, 3));
    chk_ob("R1", 32'h8000_0040);
    wr(4'd5, ctl(6, 0, 3));
    chk_ob("R1", 32'hA000_0040);

    // R5: overlapping windows, memory wins
    wr(4'd3, 32'h8000_0000);
    chk_ob("R5", 32'h8000_0010);
    chk_ob("R5", 32'h8900_0010);

    // R9: garbage low bits in bases are ignored
    wr(4'd0, 32'h8123_4567);
    wr(4'd1, 32'hF000_FFFF);
    chk_ob("R9", 32'h8000_0004);
    chk_ob("R9", 32'h8123_4567);
    wr(4'd3, 32'hA000_0000);

    // R1/R4: each size, slice clamped to window size
    for (int c = 0; c < 6; c++) begin
      wr(4'd0, 32'h4000_0000);
      wr(4'd2, ctl(c, 1, 31));
      chk_ob("R1", 32'h4000_0000 + ((32'h1 << (18 + 2 * c)) - 1));
      chk_ob("R1", 32'h4000_0000 + (32'h1 << (18 + 2 * c)));
    end
    // R4: slice below 12 clamps to 4KB
    wr(4'd2, ctl(2, 1, 3));
    chk_ob("R4", 32'h4000_0FFF);
    chk_ob("R4", 32'h4000_1000);

    // inbound BAR 256MB at 0x1000_0000 -> 0x3000_0000
    wr(4'd6, 32'h1000_0000);
    wr(4'd7, 32'h3000_0000);
    wr(4'd8, ctl(5, 0, 0));
    chk_ib("R8", 32'h1234_5678);
    wr(4'd8, ctl(5, 1, 0));
    chk_ib("R7", 32'h1234_5678);
    chk_ib("R8", 32'h2000_0000);
    wr(4'd8, ctl(0, 1, 0));
    chk_ib("R7", 32'h1003_FFFF);
    chk_ib("R8", 32'h1004_0000);
    wr(4'd7, 32'h3ABC_DEF1);
    chk_ib("R9", 32'h1000_1111);
    wr(4'd8, ctl(7, 0, 0));
    chk_ib("R1", 32'h1000_2222);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 10);
      if (r == 0) begin
        int s;
        s = int'($urandom % 9);
        if (s == 2 || s == 5 || s == 8)
          wr(4'(s), ctl(int'($urandom % 8), ($urandom % 4) != 0, int'($urandom % 32)));
        else
          wr(4'(s), $urandom);
      end
      r = int'($urandom % 4);
      if (r == 3) a = $urandom;
      else begin
        logic [31:0] b;
        int l;
        b = (r == 2) ? m_bar : m_base[r];
        l = (r == 2) ? lg(m_icode) : lg(m_code[r]);
        a = (b & ~((32'h1 << l) - 1)) | ($urandom & ((32'h1 << (l + 1)) - 1));
      end
      if (r == 2) chk_ib("R7", a);
      else chk_ob("R2", a);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule